// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table. The two most significant address bits pick a segment. The low twelve bits are an offset inside that segment. Each entry holds a physical base, a length in bytes, a writable flag and a valid flag. If the offset is inside the segment, the result is the base plus the offset.

An access that cannot be translated returns a fault code and a zero address. The fault code says whether the segment was empty, the offset was out of range, or a write hit a segment that is not writable. A kernel handler can therefore tell a copy-on-write trap (write to a protected segment) apart from a growth or zero-on-reference trap (access past the end of a segment). The table is loaded through a single-entry write port. Results are registered, so each result comes out one cycle after its request.

Top module: `seg_xlat`

## Requirements
- R1: For a valid segment, an in-range offset and a permitted access, rsp_paddr_o equals entry base plus the zero-extended 12-bit offset, modulo 2^16, and rsp_fault_o is 0 (none).
- R2: An offset greater than or equal to the entry length gives rsp_fault_o = 2 (out of bounds) and rsp_paddr_o = 0.
- R3: Any access, read or write, to an entry whose valid flag is clear gives rsp_fault_o = 1 (invalid segment) and rsp_paddr_o = 0.
- R4: A write (req_write_i = 1) to a valid entry whose writable flag is clear, with an in-range offset, gives rsp_fault_o = 3 (write-protect) and rsp_paddr_o = 0. A read of the same location translates normally.
- R5: When more than one fault applies, invalid segment wins over out of bounds, and out of bounds wins over write-protect.
- R6: The response for a request sampled at a rising edge is presented from that edge until the next one. rsp_valid_o follows req_valid_i with one cycle of delay. In a cycle with no request, rsp_paddr_o and rsp_fault_o are 0.
- R7: A table write sampled at an edge is seen only by requests sampled at later edges. A request in the same cycle as the write uses the old entry contents.
- R8: After reset every entry is invalid and all outputs are 0.
- R9: The length field is 13 bits wide. A length of 4096 admits every offset, and a length of 0 faults every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Segment table write strobe |
| tbl_idx_i | input | 2 | Entry to write |
| tbl_base_i | input | 16 | Physical base of the entry |
| tbl_len_i | input | 13 | Segment length in bytes (0 to 4096) |
| tbl_wr_ok_i | input | 1 | Entry permits writes |
| tbl_valid_i | input | 1 | Entry holds a mapping |
| req_valid_i | input | 1 | Translation request |
| req_write_i | input | 1 | Request is a write (1) or a read (0) |
| req_vaddr_i | input | 14 | Virtual address: segment in [13:12], offset in [11:0] |
| rsp_valid_o | output | 1 | Response present |
| rsp_paddr_o | output | 16 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 0 none, 1 invalid segment, 2 out of bounds, 3 write-protect |

## Verification
Every translation result and fault code is due exactly one rising edge after its request is sampled, and it stays until the next edge. The bench therefore drives on the falling edge, waits for one rising edge, and checks on the following falling edge. A table write is treated as visible one edge later. The bench sends a request in the same cycle as a rewrite of the same entry and expects the old contents, then repeats the request in the next cycle and expects the new ones. Idle cycles between sweeps are checked for an all-zero response.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned SEG_W = 2;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VA_W  = SEG_W + OFF_W;
  localparam int unsigned PA_W  = 16;
  localparam int unsigned LEN_W = OFF_W + 1;
  localparam int unsigned N_SEG = 1 << SEG_W;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_INVAL  = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_WPROT  = 2'd3
  } fault_e;

  typedef struct packed {
    logic             valid;
    logic             wr_ok;
    logic [LEN_W-1:0] len;
    logic [PA_W-1:0]  base;
  } seg_entry_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  seg_entry_t       wr_entry_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output seg_entry_t       rd_entry_o
);
  seg_entry_t tbl_q [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   tbl_q[g] <= '0;
      else if (we_i && wr_idx_i == SEG_W'(g))        tbl_q[g] <= wr_entry_i;
    end

    // R7
    ent_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(we_i) && $past(wr_idx_i) == SEG_W'(g) |-> tbl_q[g] == $past(wr_entry_i));
  end

  assign rd_entry_o = tbl_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
(
  input  seg_entry_t       entry_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             write_i,
  output logic [PA_W-1:0]  paddr_o,
  output fault_e           fault_o
);
  logic in_range;
  assign in_range = {1'b0, off_i} < entry_i.len;

  // priority: invalid > bounds > write-protect
  always_comb begin
    if (!entry_i.valid)              fault_o = FLT_INVAL;
    else if (!in_range)              fault_o = FLT_BOUNDS;
    else if (write_i && !entry_i.wr_ok) fault_o = FLT_WPROT;
    else                             fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? entry_i.base + PA_W'(off_i) : '0;
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [SEG_W-1:0] tbl_idx_i,
  input  logic [PA_W-1:0]  tbl_base_i,
  input  logic [LEN_W-1:0] tbl_len_i,
  input  logic             tbl_wr_ok_i,
  input  logic             tbl_valid_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_fault_o
);
  seg_entry_t      wr_entry, rd_entry;
  logic [PA_W-1:0] paddr_c;
  fault_e          fault_c;

  assign wr_entry = '{valid: tbl_valid_i, wr_ok: tbl_wr_ok_i, len: tbl_len_i, base: tbl_base_i};

  seg_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_idx_i),
    .wr_entry_i (wr_entry),
    .rd_idx_i   (req_vaddr_i[VA_W-1:OFF_W]),
    .rd_entry_o (rd_entry)
  );

  seg_check u_check (
    .entry_i (rd_entry),
    .off_i   (req_vaddr_i[OFF_W-1:0]),
    .write_i (req_write_i),
    .paddr_o (paddr_c),
    .fault_o (fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? paddr_c : '0;
      rsp_fault_o <= req_valid_i ? fault_c : FLT_NONE;
    end
  end

  // R2
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != FLT_NONE |-> rsp_paddr_o == '0);

  // R4
  read_no_wprot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !$past(req_write_i) |-> rsp_fault_o != FLT_WPROT);

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rsp_fault_o == FLT_NONE && rsp_paddr_o == '0);

  // R6
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i) && $past(fault_c) == FLT_NONE |-> rsp_valid_o && rsp_paddr_o == $past(paddr_c));
endmodule

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic        tbl_wr_ok = 1'b0;
  logic        tbl_valid = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_base [4];
  logic [12:0] m_len  [4];
  logic        m_wr   [4];
  logic        m_val  [4];

  always #4 clk = ~clk;

  seg_xlat uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_base_i(tbl_base),
    .tbl_len_i(tbl_len), .tbl_wr_ok_i(tbl_wr_ok), .tbl_valid_i(tbl_valid),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  task automatic check(string tag, logic v, logic [15:0] pa, logic [1:0] f);
    n_run++;
    if (rsp_valid !== v || rsp_paddr !== pa || rsp_fault !== f) begin
      n_fail++;
      $display("FAIL %s: got v=%0b pa=%h f=%0d, exp v=%0b pa=%h f=%0d",
               tag, rsp_valid, rsp_paddr, rsp_fault, v, pa, f);
    end
  endtask

  task automatic tbl_write(int i, logic [15:0] b, logic [12:0] l, logic w, logic v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'(i); tbl_base = b; tbl_len = l; tbl_wr_ok = w; tbl_valid = v;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[i] = b; m_len[i] = l; m_wr[i] = w; m_val[i] = v;
  endtask

  // expected model from the requirements
  task automatic expect_of(logic wr, logic [13:0] va, output logic [15:0] pa,
                           output logic [1:0] f, output string tag);
    int s = int'(va[13:12]);
    logic [11:0] off = va[11:0];
    pa = 16'h0;
    if (!m_val[s]) begin
      f = 2'd1;
      tag = (off >= m_len[s] || (wr && !m_wr[s])) ? "R5" : "R3";
    end else if ({1'b0, off} >= m_len[s]) begin
      f = 2'd2;
      tag = (wr && !m_wr[s]) ? "R5" : ((m_len[s] == 0) ? "R9" : "R2");
    end else if (wr && !m_wr[s]) begin
      f = 2'd3; tag = "R4";
    end else begin
      f = 2'd0; pa = m_base[s] + {4'h0, off};
      tag = (m_len[s] == 13'h1000) ? "R9" : "R1";
    end
  endtask

  task automatic xlat(logic wr, logic [13:0] va);
    logic [15:0] pa; logic [1:0] f; string tag;
    expect_of(wr, va, pa, f, tag);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 1'b1, pa, f);
  endtask

  task automatic sweep();
    for (int a = 0; a < 16384; a++) begin
      for (int w = 0; w < 2; w++) xlat(w[0], 14'(a));
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_wr[i] = 1'b0; m_val[i] = 1'b0;
    end
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check("R8", 1'b0, 16'h0, 2'd0);
    for (int s = 0; s < 4; s++) begin
      // R8: every entry invalid after reset
      xlat(1'b0, {2'(s), 12'h010});
    end

    // set A: code read-only, data, empty slot, wrapping segment
    tbl_write(0, 16'h4000, 13'h0700, 1'b0, 1'b1);
    tbl_write(1, 16'h0000, 13'h0500, 1'b1, 1'b1);
    tbl_write(2, 16'h1234, 13'h1000, 1'b1, 1'b0);
    tbl_write(3, 16'hF800, 13'h1000, 1'b1, 1'b1);
    // R1: worked example
    xlat(1'b0, 14'h0240);
    @(negedge clk);
    // R6: idle cycle gives zero outputs
    check("R6", 1'b0, 16'h0, 2'd0);
    sweep();

    // set B: zero length, full-length read-only, partial, empty with zero length
    tbl_write(0, 16'h8000, 13'h0000, 1'b1, 1'b1);
    tbl_write(1, 16'h3000, 13'h1000, 1'b0, 1'b1);
    tbl_write(2, 16'h2000, 13'h0800, 1'b1, 1'b1);
    tbl_write(3, 16'h0000, 13'h0000, 1'b0, 1'b0);
    sweep();

    // R7: request in the write cycle sees old entry, next cycle sees new
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd2; tbl_base = 16'h6000; tbl_len = 13'h0100;
    tbl_wr_ok = 1'b0; tbl_valid = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 14'h2080;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check("R7", 1'b1, 16'h2080, 2'd0);
    m_base[2] = 16'h6000; m_len[2] = 13'h0100; m_wr[2] = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 14'h2080;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7", 1'b1, 16'h0, 2'd3);
    xlat(1'b0, 14'h2080);
    @(negedge clk);
    check("R6", 1'b0, 16'h0, 2'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule